// File: doc/BRIEF.md
# Control Endpoint Handshake Status Register

This block holds the handshake state of endpoint zero, the control endpoint of a USB device controller. It tracks two handshakes between the USB engine and firmware. The first is a received OUT packet that firmware has not yet consumed. The second is a short IN packet that firmware has loaded and wants transmitted. A one-cycle event strobe from the engine reports each packet event, and firmware reaches the bits through a small register write and read port. A pending OUT packet drives a hold output that keeps the engine from entering the data phase of the next transaction.

Each handshake is a two-state machine. The OUT machine has the states `OUT_EMPTY` and `OUT_PENDING`. `OUT_EMPTY` moves to `OUT_PENDING` on a valid OUT strobe. `OUT_PENDING` moves back to `OUT_EMPTY` on a firmware write-one-to-clear, unless a new OUT strobe arrives in the same cycle. The IN machine has the states `IN_IDLE` and `IN_ARMED`. `IN_IDLE` moves to `IN_ARMED` on a firmware arm write. `IN_ARMED` returns to `IN_IDLE` on a transmit-done, control-OUT or flush strobe. A separate endpoint interrupt flag collects the interrupt-raising events, subject to an enable input. A USB bus reset returns both machines to their idle states and clears the flag.

Register map, 8-bit data. Address 0 is the endpoint register: bit 0 is OUT-ready (write 1 clears it) and bit 1 is IN-ready (write 1 sets it, reads as 0). Address 1 is the interrupt status register: bit 0 is the endpoint flag (write 1 clears it).

Top module: `ep0_handshake_csr`

## Requirements
- R1: After `rst_n` is low, `out_ready`, `in_ready`, `irq_flag`, `irq` and `data_hold` are all 0.
- R2: An `ev_out_rx` pulse sets `out_ready` at the next clock edge, and `data_hold` equals `out_ready` on every cycle.
- R3: A write to address 0 with bit 0 = 1 clears `out_ready`, and a write with bit 0 = 0 leaves it unchanged. If `ev_out_rx` arrives in the same cycle as the clear, `out_ready` stays 1.
- R4: A write to address 0 with bit 1 = 1 sets `in_ready`, and a write with bit 1 = 0 never clears it. Read data bit 1 at address 0 is always 0. Read data bit 0 at address 0 is `out_ready`.
- R5: While `in_ready` is 1, any of `ev_in_sent`, `ev_ctrl_out` or `ev_flush` clears it at the next edge.
- R6: With `irq_en` = 1, `irq_flag` is set by `ev_out_rx`, and by `in_ready` being cleared through `ev_in_sent` or `ev_ctrl_out`. A clear caused only by `ev_flush` does not set it. With `irq_en` = 0, none of these sets it.
- R7: A write to address 1 with bit 0 = 1 clears `irq_flag`, but a set event in the same cycle wins. Read data bit 0 at address 1 is `irq_flag`.
- R8: `irq` equals `irq_flag` AND `irq_en`.
- R9: A `bus_reset` cycle clears `out_ready`, `in_ready` and `irq_flag` at the next edge, overriding all other inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| bus_reset | input | 1 | USB bus reset seen, synchronous clear |
| ev_out_rx | input | 1 | Valid OUT packet received on endpoint zero |
| ev_in_sent | input | 1 | IN packet transmitted successfully |
| ev_ctrl_out | input | 1 | Control OUT received |
| ev_flush | input | 1 | Flush of the transmit FIFO requested |
| irq_en | input | 1 | Endpoint-zero interrupt enable |
| csr_wr | input | 1 | Register write strobe |
| csr_addr | input | 1 | Register select: 0 endpoint, 1 interrupt status |
| csr_wdata | input | 8 | Write data |
| csr_rdata | output | 8 | Read data for `csr_addr`, combinational |
| out_ready | output | 1 | OUT packet waiting for firmware |
| in_ready | output | 1 | Short IN packet armed for transmission |
| irq_flag | output | 1 | Endpoint-zero interrupt flag |
| irq | output | 1 | Interrupt request line |
| data_hold | output | 1 | Hold the next data phase |

## Verification
The hardest situations to reach are coincident ones. One is a firmware clear landing on the same edge as a new set event, for both the OUT bit and the interrupt flag. The other is an armed IN packet retired in the same cycle by a flush together with a transmit-done or a control OUT, which must still raise the flag. Directed cycles drive these exact coincidences, including a masked retire and a flush-only retire. A long run of random strobes and writes, with sparse bus resets, is then compared on every clock against a behavioural model of the bits.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;
    localparam int CSR_DW        = 8;
    localparam int BIT_OUT_READY = 0;
    localparam int BIT_IN_READY  = 1;
    localparam int BIT_EP0_FLAG  = 0;

    typedef enum logic {OUT_EMPTY = 1'b0, OUT_PENDING = 1'b1} out_state_e;
    typedef enum logic {IN_IDLE = 1'b0, IN_ARMED = 1'b1} in_state_e;
endpackage

// File: rtl/ep0_out_fsm.sv
module ep0_out_fsm
    import ep0_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic rx_evt,
    input  logic cpu_clr,
    output logic pending,
    output logic set_pulse
);
    out_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OUT_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (bus_reset) begin
            state_d = OUT_EMPTY;
        end else begin
            unique case (state_q)
                OUT_EMPTY:   if (rx_evt) state_d = OUT_PENDING;
                OUT_PENDING: if (!rx_evt && cpu_clr) state_d = OUT_EMPTY;
                default:     state_d = OUT_EMPTY;
            endcase
        end
    end

    always_comb begin
        pending   = 1'b0;
        set_pulse = rx_evt && !bus_reset;
        unique case (state_q)
            OUT_EMPTY:   pending = 1'b0;
            OUT_PENDING: pending = 1'b1;
            default:     pending = 1'b0;
        endcase
    end
endmodule

// File: rtl/ep0_in_fsm.sv
module ep0_in_fsm
    import ep0_csr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic cpu_arm,
    input  logic sent_evt,
    input  logic ctrl_out_evt,
    input  logic flush_evt,
    output logic armed,
    output logic done_pulse
);
    in_state_e state_q, state_d;
    logic      retire;

    assign retire = sent_evt || ctrl_out_evt || flush_evt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IN_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (bus_reset) begin
            state_d = IN_IDLE;
        end else begin
            unique case (state_q)
                IN_IDLE:  if (cpu_arm) state_d = IN_ARMED;
                IN_ARMED: if (retire)  state_d = IN_IDLE;
                default:  state_d = IN_IDLE;
            endcase
        end
    end

    always_comb begin
        armed      = 1'b0;
        done_pulse = 1'b0;
        unique case (state_q)
            IN_IDLE: begin
                armed      = 1'b0;
                done_pulse = 1'b0;
            end
            IN_ARMED: begin
                armed      = 1'b1;
                done_pulse = !bus_reset && (sent_evt || ctrl_out_evt);
            end
            default: begin
                armed      = 1'b0;
                done_pulse = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/ep0_irq_flag.sv
module ep0_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_reset,
    input  logic set_a,
    input  logic set_b,
    input  logic enable,
    input  logic cpu_clr,
    output logic flag,
    output logic req
);
    logic flag_q, flag_d, set_any;

    assign set_any = (set_a || set_b) && enable;

    always_comb begin
        flag_d = flag_q;
        if (bus_reset)    flag_d = 1'b0;
        else if (set_any) flag_d = 1'b1;
        else if (cpu_clr) flag_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;
    assign req  = flag_q && enable;
endmodule

// File: rtl/ep0_handshake_csr.sv
module ep0_handshake_csr
    import ep0_csr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_reset,
    input  logic              ev_out_rx,
    input  logic              ev_in_sent,
    input  logic              ev_ctrl_out,
    input  logic              ev_flush,
    input  logic              irq_en,
    input  logic              csr_wr,
    input  logic              csr_addr,
    input  logic [CSR_DW-1:0] csr_wdata,
    output logic [CSR_DW-1:0] csr_rdata,
    output logic              out_ready,
    output logic              in_ready,
    output logic              irq_flag,
    output logic              irq,
    output logic              data_hold
);
    logic wr_ep, wr_irq;
    logic out_clr, in_arm, flag_clr;
    logic out_set_pulse, in_done_pulse;
    logic unused_wdata_bits;

    assign wr_ep    = csr_wr && !csr_addr;
    assign wr_irq   = csr_wr &&  csr_addr;
    assign out_clr  = wr_ep  && csr_wdata[BIT_OUT_READY];
    assign in_arm   = wr_ep  && csr_wdata[BIT_IN_READY];
    assign flag_clr = wr_irq && csr_wdata[BIT_EP0_FLAG];
    assign unused_wdata_bits = ^csr_wdata;

    ep0_out_fsm u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .rx_evt    (ev_out_rx),
        .cpu_clr   (out_clr),
        .pending   (out_ready),
        .set_pulse (out_set_pulse)
    );

    ep0_in_fsm u_in (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_reset    (bus_reset),
        .cpu_arm      (in_arm),
        .sent_evt     (ev_in_sent),
        .ctrl_out_evt (ev_ctrl_out),
        .flush_evt    (ev_flush),
        .armed        (in_ready),
        .done_pulse   (in_done_pulse)
    );

    ep0_irq_flag u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_reset (bus_reset),
        .set_a     (out_set_pulse),
        .set_b     (in_done_pulse),
        .enable    (irq_en),
        .cpu_clr   (flag_clr),
        .flag      (irq_flag),
        .req       (irq)
    );

    assign data_hold = out_ready;

    always_comb begin
        csr_rdata = '0;
        if (!csr_addr) csr_rdata[BIT_OUT_READY] = out_ready;
        else           csr_rdata[BIT_EP0_FLAG]  = irq_flag;
    end
endmodule

// File: rtl/ep0_handshake_csr_checker.sv
module ep0_handshake_csr_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       bus_reset,
    input logic       ev_out_rx,
    input logic       ev_in_sent,
    input logic       ev_ctrl_out,
    input logic       ev_flush,
    input logic       irq_en,
    input logic       csr_addr,
    input logic [7:0] csr_rdata,
    input logic       out_ready,
    input logic       in_ready,
    input logic       irq_flag,
    input logic       irq
);
    p_out_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_out_rx && !bus_reset) |=> out_ready);

    p_in_reads_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_addr |-> (csr_rdata[1] == 1'b0));

    p_in_retire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && (ev_in_sent || ev_ctrl_out || ev_flush)) |=> !in_ready);

    p_flush_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_flush && !ev_in_sent && !ev_ctrl_out && !ev_out_rx && !irq_flag)
        |=> !irq_flag);

    p_done_raises_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready && irq_en && (ev_in_sent || ev_ctrl_out) && !bus_reset)
        |=> irq_flag);

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    p_bus_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (!out_ready && !in_ready && !irq_flag));
endmodule

bind ep0_handshake_csr ep0_handshake_csr_checker u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_reset   (bus_reset),
    .ev_out_rx   (ev_out_rx),
    .ev_in_sent  (ev_in_sent),
    .ev_ctrl_out (ev_ctrl_out),
    .ev_flush    (ev_flush),
    .irq_en      (irq_en),
    .csr_addr    (csr_addr),
    .csr_rdata   (csr_rdata),
    .out_ready   (out_ready),
    .in_ready    (in_ready),
    .irq_flag    (irq_flag),
    .irq         (irq)
);

// File: tb/ep0_handshake_csr_bench.sv
`timescale 1ns/1ps
module ep0_handshake_csr_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 1'b0;
    logic       ev_out_rx = 1'b0, ev_in_sent = 1'b0, ev_ctrl_out = 1'b0, ev_flush = 1'b0;
    logic       irq_en = 1'b0;
    logic       csr_wr = 1'b0, csr_addr = 1'b0;
    logic [7:0] csr_wdata = 8'h00;
    logic [7:0] csr_rdata;
    logic       out_ready, in_ready, irq_flag, irq, data_hold;

    int checks = 0;
    int failures = 0;
    bit m_out = 0, m_in = 0, m_flag = 0;

    always #2 clk = ~clk;

    ep0_handshake_csr u_ep0_handshake_csr (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset),
        .ev_out_rx(ev_out_rx), .ev_in_sent(ev_in_sent),
        .ev_ctrl_out(ev_ctrl_out), .ev_flush(ev_flush), .irq_en(irq_en),
        .csr_wr(csr_wr), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .out_ready(out_ready), .in_ready(in_ready),
        .irq_flag(irq_flag), .irq(irq), .data_hold(data_hold)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(input string tag);
        logic [7:0] exp_rd;
        exp_rd = 8'h00;
        if (!csr_addr) exp_rd[0] = m_out; else exp_rd[0] = m_flag;
        check(tag,  "out_ready", int'(out_ready), int'(m_out));
        check(tag,  "in_ready",  int'(in_ready),  int'(m_in));
        check(tag,  "irq_flag",  int'(irq_flag),  int'(m_flag));
        check("R2", "data_hold", int'(data_hold), int'(m_out));
        check("R8", "irq",       int'(irq),       int'(m_flag && irq_en));
        check("R4", "csr_rdata", int'(csr_rdata), int'(exp_rd));
    endtask

    task automatic cyc(input string tag, input bit rx, input bit sent, input bit cout,
                       input bit fl, input bit wr, input bit addr, input logic [7:0] wd,
                       input bit en, input bit brst);
        bit done, n_out, n_in, n_flag;
        @(negedge clk);
        ev_out_rx = rx; ev_in_sent = sent; ev_ctrl_out = cout; ev_flush = fl;
        csr_wr = wr; csr_addr = addr; csr_wdata = wd; irq_en = en; bus_reset = brst;
        done = m_in && (sent || cout);
        if (brst) begin
            n_out = 0; n_in = 0; n_flag = 0;
        end else begin
            n_out = rx ? 1'b1 : ((wr && !addr && wd[0]) ? 1'b0 : m_out);
            if (m_in) n_in = !(sent || cout || fl);
            else      n_in = wr && !addr && wd[1];
            if ((rx || done) && en)        n_flag = 1;
            else if (wr && addr && wd[0])  n_flag = 0;
            else                           n_flag = m_flag;
        end
        @(posedge clk);
        m_out = n_out; m_in = n_in; m_flag = n_flag;
        #1;
        compare_all(tag);
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compare_all("R1");
        @(negedge clk);
        rst_n = 1'b1;

        cyc("R2", 1,0,0,0, 0,0,8'h00, 1,0);  // OUT arrives, flag set
        cyc("R3", 0,0,0,0, 1,0,8'h00, 1,0);  // write zero: no effect
        cyc("R3", 0,0,0,0, 1,0,8'h01, 1,0);  // W1C
        cyc("R3", 1,0,0,0, 1,0,8'h01, 1,0);  // set wins over clear
        cyc("R7", 0,0,0,0, 1,1,8'h01, 1,0);  // clear flag
        cyc("R4", 0,0,0,0, 1,0,8'h02, 1,0);  // arm IN, read bit1 = 0
        cyc("R4", 0,0,0,0, 1,0,8'h00, 1,0);  // zero write keeps armed
        cyc("R6", 0,0,0,1, 0,0,8'h00, 1,0);  // flush: no interrupt
        cyc("R5", 0,0,0,0, 1,0,8'h02, 1,0);
        cyc("R6", 0,1,0,0, 0,1,8'h00, 1,0);  // sent raises flag
        cyc("R7", 0,0,0,0, 1,1,8'h01, 0,0);
        cyc("R5", 0,0,0,0, 1,0,8'h02, 0,0);
        cyc("R6", 0,0,1,0, 0,1,8'h00, 0,0);  // ctrl out masked
        cyc("R5", 0,0,0,0, 1,0,8'h02, 1,0);
        cyc("R6", 0,0,1,1, 0,1,8'h00, 1,0);  // flush with ctrl out raises
        cyc("R7", 1,0,0,0, 1,1,8'h01, 1,0);  // set wins over flag clear
        cyc("R8", 0,0,0,0, 0,1,8'h00, 0,0);  // masked line
        cyc("R5", 0,0,0,0, 1,0,8'h02, 1,0);
        cyc("R9", 1,1,0,0, 1,0,8'h02, 1,1);  // bus reset overrides
        cyc("R9", 0,0,0,0, 0,1,8'h00, 1,0);

        for (int i = 0; i < 2000; i++) begin
            logic [7:0] wd;
            wd = 8'($urandom);
            cyc("R5", ($urandom % 5) == 0, ($urandom % 6) == 0, ($urandom % 9) == 0,
                ($urandom % 9) == 0, ($urandom % 3) == 0, 1'($urandom), wd,
                ($urandom % 4) != 0, ($urandom % 97) == 0);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule